// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only control port driven over three wires: an active-low select, a serial clock and a serial data line. While select is low, each rising edge of the serial clock shifts one data bit into a frame assembler. When select returns high, a frame that held exactly sixteen bits is committed into a small bank of control words; any other bit count throws the frame away. Each frame carries a 2-bit operation code, a 4-bit register address and a 10-bit data word, sent most significant bit first.

The three pins are asynchronous to the core clock and pass through synchronizers, so the core clock must run several times faster than the serial clock (serial clock up to 10 MHz). The bank holds five words, and each keeps only the bits its fields need. The decoded fields go straight to the analog front-end controls. A one-cycle strobe marks every committed write, so that neighbouring logic (for example a gain-boost period counter) can restart on any access.

Top module: `ctl_serial_port`

## Requirements
- R1: While `rst_n` is low and right after it rises, every control output is zero except `black_lvl_o`, which reads 64, and `wr_strobe_o` is low.
- R2: Bits are sampled on rising edges of `sclk_i` while `cs_n_i` is low, in this order: operation code (2 bits), address (4 bits), then data (10 bits), each field sent most significant bit first.
- R3: A frame of exactly 16 bits is committed after `cs_n_i` rises, and the addressed word takes the new data.
- R4: A frame of fewer than 16 bits, including one with no clock edges at all, changes no output and raises no strobe.
- R5: A frame of more than 16 bits changes no output and raises no strobe.
- R6: A complete frame to any address from 5 to 15 changes no output and raises no strobe.
- R7: The operation code is not interpreted: frames that differ only in their operation code have the same effect.
- R8: Each committed write raises `wr_strobe_o` for exactly one core clock cycle.
- R9: Field map of the data word D[9:0]. Address 0 stores D[9:0] to `mode1_o`. Address 1 stores D[7:0] to `mode2_o`. Address 2 stores D[5:4] to `cds_gain_o`, D[3] to `boost_hold_o` and D[2:0] to `boost_len_o`. Address 3 stores D[8:7] to `pga_coarse_o` and D[6:0] to `pga_fine_o`. Address 4 stores D[6:0] to `black_lvl_o`. Data bits outside these fields are dropped.
- R10: Serial clock edges while `cs_n_i` is high are ignored. Each new select starts its bit count from zero.
- R11: An asserted `rst_n` in the middle of a frame returns all words to their defaults. The rest of that frame is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low select, high when idle |
| sdi_i | input | 1 | Serial data |
| mode1_o | output | 10 | Mode word at address 0 |
| mode2_o | output | 8 | Mode word at address 1 |
| cds_gain_o | output | 2 | Sampler gain code |
| boost_hold_o | output | 1 | Keep black-loop gain high |
| boost_len_o | output | 3 | Boost length in black periods |
| pga_coarse_o | output | 2 | Amplifier coarse gain step |
| pga_fine_o | output | 7 | Amplifier fine gain step |
| black_lvl_o | output | 7 | Black level target code |
| wr_strobe_o | output | 1 | One-cycle pulse per committed write |

## Verification
The hardest case to reach is a select released while the bit counter holds a value other than sixteen. This happens after one short burst of clocks, after seventeen clocks, or after a reset that clears the counter in the middle of a frame. The stimulus gets there with a frame task that takes an explicit bit count, so that lengths 0, 1, 15 and 17 are sent. A separate sequence asserts reset partway through a frame and only releases select afterwards. Serial clock bursts sent with select high, followed by a full frame, show that idle edges leave no bits behind.

// File: rtl/csp_pkg.sv
package csp_pkg;

  localparam int DATA_W        = 10;
  localparam int ADDR_W        = 4;
  localparam int OP_W          = 2;
  localparam int FRAME_BITS    = OP_W + ADDR_W + DATA_W;
  localparam int NUM_REGS      = 5;
  localparam int BLACK_DEFAULT = 64;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MODE_A = 4'd0,
    ADR_MODE_B = 4'd1,
    ADR_SAMPLE = 4'd2,
    ADR_GAIN   = 4'd3,
    ADR_BLACK  = 4'd4
  } reg_addr_e;

  // Stored width of each control word; bits above it are dropped on write.
  function automatic int reg_width(int idx);
    case (idx)
      ADR_MODE_A: return 10;
      ADR_MODE_B: return 8;
      ADR_SAMPLE: return 6;
      ADR_GAIN:   return 9;
      default:    return 7;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    return (idx == ADR_BLACK) ? DATA_W'(BLACK_DEFAULT) : '0;
  endfunction

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int              W        = 1,
  parameter int              STAGES   = 2,
  parameter logic [W-1:0]    RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= RST_VAL;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/csp_frame_rx.sv
module csp_frame_rx
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output logic              frm_valid_o,
  output logic [ADDR_W-1:0] frm_addr_o,
  output logic [DATA_W-1:0] frm_data_o
);

  localparam int SHIFT_W = ADDR_W + DATA_W;
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_q, cs_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHIFT_W-1:0] shreg_q, shreg_d;
  logic               valid_q, valid_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               sclk_rise, cs_rise, shift_en, commit;

  // Operation code bits fall out of the top of the shift register unused.
  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    cs_rise   = cs_n_s & ~cs_q;
    shift_en  = sclk_rise & ~cs_n_s;
    commit    = cs_rise && (cnt_q == CNT_W'(FRAME_BITS));

    cnt_d = cnt_q;
    if (cs_n_s)                                      cnt_d = '0;
    else if (shift_en && cnt_q != CNT_W'(CNT_MAX))   cnt_d = cnt_q + 1'b1;

    shreg_d = shift_en ? {shreg_q[SHIFT_W-2:0], sdi_s} : shreg_q;
    valid_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
      valid_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      cs_q    <= cs_n_s;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (commit) begin
      addr_q <= shreg_q[SHIFT_W-1:DATA_W];
      data_q <= shreg_q[DATA_W-1:0];
    end
  end

  assign frm_valid_o = valid_q;
  assign frm_addr_o  = addr_q;
  assign frm_data_o  = data_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R5

  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(cnt_q) == CNT_W'(FRAME_BITS))); // R3

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_n_s) |=> (cnt_q == '0)); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R8

endmodule

// File: rtl/csp_reg_bank.sv
module csp_reg_bank
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] words_o [NUM_REGS],
  output logic              strobe_o
);

  logic [NUM_REGS-1:0] hit;
  logic                strobe_q, strobe_d;

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++)
      hit[k] = wr_valid_i && (wr_addr_i == ADDR_W'(k));
    strobe_d = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      localparam int           W   = reg_width(i);
      localparam logic [W-1:0] RST = W'(reg_default(i));
      logic [W-1:0] word_q, word_d;

      always_comb word_d = hit[i] ? wr_data_i[W-1:0] : word_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RST;
        else        word_q <= word_d;
      end

      assign words_o[i] = DATA_W'(word_q);

      AST_WORD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> strobe_q); // R6
    end
  endgenerate

  assign strobe_o = strobe_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q); // R8

  AST_UNDEF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_addr_i >= ADDR_W'(NUM_REGS)) |=> !strobe_q); // R6

  AST_STROBE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(wr_valid_i)); // R3

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import csp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       sdi_i,
  output logic [9:0] mode1_o,
  output logic [7:0] mode2_o,
  output logic [1:0] cds_gain_o,
  output logic       boost_hold_o,
  output logic [2:0] boost_len_o,
  output logic [1:0] pga_coarse_o,
  output logic [6:0] pga_fine_o,
  output logic [6:0] black_lvl_o,
  output logic       wr_strobe_o
);

  logic [2:0]        pins_s;
  logic              frm_valid;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  logic [DATA_W-1:0] words [NUM_REGS];

  // Bit order: {sdi, cs_n, sclk}; select idles high.
  csp_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdi_i, cs_n_i, sclk_i}),
    .sync_o  (pins_s)
  );

  csp_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (pins_s[0]),
    .cs_n_s      (pins_s[1]),
    .sdi_s       (pins_s[2]),
    .frm_valid_o (frm_valid),
    .frm_addr_o  (frm_addr),
    .frm_data_o  (frm_data)
  );

  csp_reg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (frm_valid),
    .wr_addr_i  (frm_addr),
    .wr_data_i  (frm_data),
    .words_o    (words),
    .strobe_o   (wr_strobe_o)
  );

  assign mode1_o      = words[ADR_MODE_A];
  assign mode2_o      = words[ADR_MODE_B][7:0];
  assign cds_gain_o   = words[ADR_SAMPLE][5:4];
  assign boost_hold_o = words[ADR_SAMPLE][3];
  assign boost_len_o  = words[ADR_SAMPLE][2:0];
  assign pga_coarse_o = words[ADR_GAIN][8:7];
  assign pga_fine_o   = words[ADR_GAIN][6:0];
  assign black_lvl_o  = words[ADR_BLACK][6:0];

  // Upper bits of narrow words are held at zero by the bank.
  logic unused_hi;
  assign unused_hi = ^{words[ADR_MODE_B][9:8], words[ADR_SAMPLE][9:6],
                       words[ADR_GAIN][9], words[ADR_BLACK][9:7]};

endmodule

// File: tb/ctl_serial_port_tb.sv
module ctl_serial_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 3;
  localparam int NVEC       = 14;

  // {op[1:0], addr[3:0], data[9:0], nbits[4:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 4'd0,  10'h1A5, 5'd16},
    {2'd3, 4'd1,  10'h3C3, 5'd16},
    {2'd1, 4'd2,  10'h2B6, 5'd16},
    {2'd0, 4'd3,  10'h3FF, 5'd16},
    {2'd2, 4'd4,  10'h010, 5'd16},
    {2'd0, 4'd4,  10'h07F, 5'd15},
    {2'd0, 4'd3,  10'h055, 5'd17},
    {2'd0, 4'd5,  10'h3FF, 5'd16},
    {2'd1, 4'd15, 10'h000, 5'd16},
    {2'd0, 4'd0,  10'h000, 5'd1},
    {2'd2, 4'd2,  10'h00F, 5'd16},
    {2'd3, 4'd3,  10'h100, 5'd16},
    {2'd0, 4'd4,  10'h3C1, 5'd16},
    {2'd0, 4'd1,  10'h000, 5'd0}
  };

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, sdi;
  logic [9:0] mode1;
  logic [7:0] mode2;
  logic [1:0] cds_gain, pga_coarse;
  logic       boost_hold, strobe;
  logic [2:0] boost_len;
  logic [6:0] pga_fine, black_lvl;

  int checks = 0, failures = 0;
  int strobe_cnt = 0, wide_strobe = 0;
  logic strobe_prev = 1'b0;
  bit done = 1'b0;

  // Bench model of the bank, from the field map.
  logic [9:0] m_w [5];

  ctl_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .mode1_o(mode1), .mode2_o(mode2), .cds_gain_o(cds_gain),
    .boost_hold_o(boost_hold), .boost_len_o(boost_len),
    .pga_coarse_o(pga_coarse), .pga_fine_o(pga_fine),
    .black_lvl_o(black_lvl), .wr_strobe_o(strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (strobe) strobe_cnt++;
    if (strobe && strobe_prev) wide_strobe++;
    strobe_prev <= strobe;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 5; k++) m_w[k] = '0;
    m_w[4] = 10'd64;
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    check({req, " mode1"},  mode1,      m_w[0]);
    check({req, " mode2"},  mode2,      m_w[1][7:0]);
    check({req, " cds"},    cds_gain,   m_w[2][5:4]);
    check({req, " hold"},   boost_hold, m_w[2][3]);
    check({req, " len"},    boost_len,  m_w[2][2:0]);
    check({req, " coarse"}, pga_coarse, m_w[3][8:7]);
    check({req, " fine"},   pga_fine,   m_w[3][6:0]);
    check({req, " black"},  black_lvl,  m_w[4][6:0]);
  endtask

  task automatic send_frame(logic [1:0] op, logic [3:0] addr, logic [9:0] data, int nbits);
    logic [15:0] f;
    f = {op, addr, data};
    cs_n = 1'b0;
    repeat (HALF_SCK) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 16) ? f[15-i] : 1'b0;
      sclk = 1'b0;
      repeat (HALF_SCK) @(posedge clk);
      sclk = 1'b1;
      repeat (HALF_SCK) @(posedge clk);
    end
    sclk = 1'b0;
    repeat (HALF_SCK) @(posedge clk);
    cs_n = 1'b1;
    repeat (10) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    model_reset();
    repeat (4) @(posedge clk);
    check_all("R1 in reset");
    check("R1 strobe", strobe, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    check_all("R1 after reset");

    // Table walk: commits, short, long, undefined addresses, opcodes.
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op; logic [3:0] ad; logic [9:0] dt; int nb; bit ok;
      string tag;
      {op, ad, dt} = VEC[v][20:5];
      nb = int'(VEC[v][4:0]);
      ok = (nb == 16) && (ad < 4'd5);
      tag = (nb < 16) ? "R4" : (nb > 16) ? "R5" : (ad >= 4'd5) ? "R6" : "R2/R3/R9";
      s0 = strobe_cnt;
      send_frame(op, ad, dt, nb);
      if (ok) m_w[ad] = dt;
      check_all(tag);
      check({tag, " R8 strobe count"}, strobe_cnt - s0, ok ? 1 : 0);
    end
    check("R8 strobe width", wide_strobe, 0);

    // R7: same frame with two different opcodes.
    send_frame(2'd0, 4'd4, 10'h022, 16);
    m_w[4] = 10'h022;
    check_all("R7 op0");
    send_frame(2'd0, 4'd4, 10'h000, 16);
    send_frame(2'd3, 4'd4, 10'h022, 16);
    check_all("R7 op3");

    // R10: serial clock toggled with select high, then a full frame.
    s0 = strobe_cnt;
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b1; repeat (HALF_SCK) @(posedge clk);
      sclk = 1'b0; repeat (HALF_SCK) @(posedge clk);
    end
    repeat (5) @(posedge clk);
    check_all("R10 idle clocks");
    check("R10 idle strobe", strobe_cnt - s0, 0);
    send_frame(2'd1, 4'd0, 10'h2C4, 16);
    m_w[0] = 10'h2C4;
    check_all("R10 frame after idle");

    // R11: reset in the middle of a frame.
    s0 = strobe_cnt;
    cs_n = 1'b0;
    repeat (HALF_SCK) @(posedge clk);
    for (int i = 0; i < 9; i++) begin
      sdi = i[0]; sclk = 1'b0; repeat (HALF_SCK) @(posedge clk);
      sclk = 1'b1; repeat (HALF_SCK) @(posedge clk);
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 7; i++) begin
      sdi = 1'b1; sclk = 1'b0; repeat (HALF_SCK) @(posedge clk);
      sclk = 1'b1; repeat (HALF_SCK) @(posedge clk);
    end
    sclk = 1'b0;
    repeat (HALF_SCK) @(posedge clk);
    cs_n = 1'b1;
    repeat (10) @(posedge clk);
    model_reset();
    check_all("R11 mid-frame reset");
    check("R11 strobe", strobe_cnt - s0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule